// File: doc/BRIEF.md
# Streaming Unsharp Mask Pipeline

This block sharpens a raster pixel stream of 8-bit unsigned samples. Each accepted input pixel advances a two-stage stencil pipeline by one step. The first stage averages three horizontally adjacent raw pixels. The second stage averages three vertically adjacent results of the first stage, using storage for two lines of those intermediate values. The vertical result is a low-pass copy of the image. It is subtracted from a copy of the original pixel, delayed to line up with it; the difference is scaled by roughly one tenth, added back to the pixel and saturated to 0..255.

The pipeline is a small graph rather than a chain, because the final combining step reads both the blurred intermediate and the raw input. The raw path therefore has its own delay line, sized so that the raw pixel and the blur of the same (x, y) meet in the same step. Line width and frame height are parameters. Producers mark the first pixel of each line and of each frame. The block echoes these markers on its output and raises a flag when the 3x3 window of the output pixel lies fully inside the frame.

Top module: `usharp_stream`

## Requirements
- R1: After reset, out_valid, out_inner, out_sol and out_sof are low until the pipeline has taken in enough pixels.
- R2: out_valid is high in the cycle after an accepted input (in_valid high at a clock edge) whose stream index k satisfies k >= LINE_W+3, and is low in every other cycle.
- R3: The horizontal stage value for pixel (x, y) is ((I(x-1,y) + I(x,y) + I(x+1,y)) * 21846 + 32768) >> 16.
- R4: The blur value for (x, y) applies the same rounded divide by three to the sum of the horizontal stage values at rows y-1, y and y+1 of column x.
- R5: For an interior pixel, out_pix equals I + ((I - blur) * 205 >>> 11), with the difference signed and the shift arithmetic (rounding toward minus infinity), saturated to 0..255.
- R6: The output produced after accepting stream index k belongs to stream index k - LINE_W - 3, so latency is one line plus three pixels.
- R7: out_inner is high exactly for valid outputs whose column is neither 0 nor LINE_W-1 and whose row is neither 0 nor ROWS-1. out_pix is meaningful only when out_inner is high.
- R8: With out_valid high, out_sol is high exactly for column 0, and out_sof is high exactly for column 0 of row 0.
- R9: A sharpened value above 255 is output as 255, and one below 0 is output as 0.
- R10: A cycle with in_valid low advances nothing. out_valid is low in the next cycle, out_pix holds its value, and results after the gap equal those of a gap-free stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_pix | input | 8 | Input pixel value |
| in_sol | input | 1 | Input pixel is column 0 of its line |
| in_sof | input | 1 | Input pixel is column 0 of row 0 of a frame |
| out_valid | output | 1 | Output pixel present this cycle |
| out_pix | output | 8 | Sharpened pixel value |
| out_sol | output | 1 | Output pixel is column 0 |
| out_sof | output | 1 | Output pixel is the first of a frame |
| out_inner | output | 1 | Full 3x3 window lay inside the frame |

## Verification
The properties assume a well-formed input stream. Every line carries exactly LINE_W accepted pixels, with in_sol on the first. Every frame carries exactly ROWS lines, with in_sof on its first pixel. The first pixel after reset starts a frame. The bench builds its stream from whole frames: it raises the markers from the pixel's stream index and spreads idle cycles only between accepted pixels. Idle cycles carry random pixel and marker-free data, so any leak of an idle value into the result would show up.

// File: rtl/usharp_stream.sv
module usharp_stream #(
  parameter int LINE_W = 64,
  parameter int ROWS   = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_pix,
  input  logic       in_sol,
  input  logic       in_sof,
  output logic       out_valid,
  output logic [7:0] out_pix,
  output logic       out_sol,
  output logic       out_sof,
  output logic       out_inner
);
  localparam int XW   = (LINE_W > 1) ? $clog2(LINE_W) : 1;
  localparam int YW   = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int VLEN = 2 * LINE_W + 1;

  // word: {live, sof, sol, pixel}
  logic [10:0] h0, h1, h2;
  logic [10:0] rd [LINE_W];
  logic [7:0]  vd [VLEN];
  logic [XW-1:0] px_q;
  logic [YW-1:0] py_q;

  wire [9:0] hsum  = {2'b0, h0[7:0]} + {2'b0, h1[7:0]} + {2'b0, h2[7:0]};
  wire [7:0] hblur = 8'((32'(hsum) * 32'd21846 + 32'd32768) >> 16);
  wire [9:0] vsum  = {2'b0, vd[0]} + {2'b0, vd[LINE_W]} + {2'b0, vd[2*LINE_W]};
  wire [7:0] vblur = 8'((32'(vsum) * 32'd21846 + 32'd32768) >> 16);

  wire [10:0] ctr   = rd[LINE_W-1];
  wire        c_live = ctr[10];
  wire        c_sof  = ctr[9];
  wire        c_sol  = ctr[8];
  wire [7:0]  c_pix  = ctr[7:0];

  wire [XW-1:0] cx = c_sol ? '0 : px_q + 1'b1;
  wire [YW-1:0] cy = c_sof ? '0 : (c_sol ? py_q + 1'b1 : py_q);

  wire signed [9:0]  diff  = $signed({2'b0, c_pix}) - $signed({2'b0, vblur});
  wire signed [17:0] prod  = diff * 18'sd205;
  wire signed [10:0] adj   = 11'(prod >>> 11);
  wire signed [10:0] sharp = $signed({3'b0, c_pix}) + adj;
  wire [7:0] sat = (sharp < 11'sd0)   ? 8'd0 :
                   (sharp > 11'sd255) ? 8'd255 : sharp[7:0];

  wire inner = c_live && (cx != '0) && (cx != XW'(LINE_W-1)) &&
               (cy != '0) && (cy != YW'(ROWS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h0 <= '0; h1 <= '0; h2 <= '0;
      for (int i = 0; i < LINE_W; i++) rd[i] <= '0;
      for (int i = 0; i < VLEN; i++) vd[i] <= '0;
      px_q <= '0; py_q <= '0;
      out_valid <= 1'b0; out_pix <= '0;
      out_sol <= 1'b0; out_sof <= 1'b0; out_inner <= 1'b0;
    end else if (in_valid) begin
      h0 <= {1'b1, in_sof, in_sol, in_pix};
      h1 <= h0;
      h2 <= h1;
      rd[0] <= h2;
      for (int i = 1; i < LINE_W; i++) rd[i] <= rd[i-1];
      vd[0] <= hblur;
      for (int i = 1; i < VLEN; i++) vd[i] <= vd[i-1];
      if (c_live) begin
        px_q <= cx;
        py_q <= cy;
      end
      out_valid <= c_live;
      out_pix   <= sat;
      out_sol   <= c_live && c_sol;
      out_sof   <= c_live && c_sof;
      out_inner <= inner;
    end else begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_sof   <= 1'b0;
      out_inner <= 1'b0;
    end
  end
endmodule

// File: rtl/usharp_stream_chk.sv
module usharp_stream_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic [7:0] out_pix,
  input logic       out_sol,
  input logic       out_sof,
  input logic       out_inner
);
  a_r2_out_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  a_r7_inner_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_inner |-> out_valid);
  a_r7_first_col_not_inner: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sol) |-> !out_inner);
  a_r8_sof_implies_sol: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_sol);
  a_r8_markers_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sol || out_sof) |-> out_valid);
  a_r10_hold_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_pix));
endmodule

bind usharp_stream usharp_stream_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_pix(out_pix), .out_sol(out_sol), .out_sof(out_sof), .out_inner(out_inner)
);

// File: tb/usharp_stream_tb.sv
`timescale 1ns/1ps
module usharp_stream_tb;
  localparam int W = 8;
  localparam int R = 5;
  localparam int FR = W * R;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
  logic [7:0] in_pix = '0;
  logic out_valid, out_sol, out_sof, out_inner;
  logic [7:0] out_pix;

  usharp_stream #(.LINE_W(W), .ROWS(R)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_sol(in_sol), .in_sof(in_sof), .out_valid(out_valid), .out_pix(out_pix),
    .out_sol(out_sol), .out_sof(out_sof), .out_inner(out_inner));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  int pix [1024];
  int n = 0;
  bit last_acc = 0;
  int last_idx = 0;
  int seed = 7;

  task automatic chk(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int div3(int s);
    return (s * 21846 + 32768) >>> 16;
  endfunction

  function automatic int hval(int i);   // R3
    return div3(pix[i-1] + pix[i] + pix[i+1]);
  endfunction

  function automatic int raw_sharp(int c);  // R4 then R5 before clamp
    int b = div3(hval(c - W) + hval(c) + hval(c + W));
    int d = pix[c] - b;
    return pix[c] + ((d * 205) >>> 11);
  endfunction

  task automatic check_prev();
    if (!last_acc) begin
      chk("R10 idle no output", int'(out_valid), 0);
    end else begin
      int c = last_idx - (W + 3);
      if (c < 0) begin
        chk("R2 pipeline filling", int'(out_valid), 0);
      end else begin
        int x = c % W;
        int y = (c / W) % R;
        int in_exp = (x != 0 && x != W-1 && y != 0 && y != R-1) ? 1 : 0;
        chk("R2 R6 valid", int'(out_valid), 1);
        chk("R8 sol", int'(out_sol), (x == 0) ? 1 : 0);
        chk("R8 sof", int'(out_sof), (x == 0 && y == 0) ? 1 : 0);
        chk("R7 inner", int'(out_inner), in_exp);
        if (in_exp == 1) begin
          int r = raw_sharp(c);
          if (r > 255) chk("R9 high clamp", int'(out_pix), 255);
          else if (r < 0) chk("R9 low clamp", int'(out_pix), 0);
          else chk("R5 sharpened", int'(out_pix), r);
        end
      end
    end
  endtask

  task automatic push(bit v, int p);
    @(negedge clk);
    check_prev();
    in_valid = v;
    in_pix   = 8'(p);
    in_sol   = v && (n % W == 0);
    in_sof   = v && (n % FR == 0);
    last_acc = v;
    last_idx = n;
    if (v) begin
      pix[n] = p;
      n++;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", int'(out_valid), 0);
    chk("R1 reset inner", int'(out_inner), 0);
    rst_n = 1'b1;
    // frame 0: random, continuous
    for (int i = 0; i < FR; i++) push(1, int'($urandom_range(0, 255)));
    // frame 1: random with idle gaps (R10)
    for (int i = 0; i < FR; i++) begin
      while ($urandom_range(0, 2) == 0) push(0, int'($urandom_range(0, 255)));
      push(1, int'($urandom_range(0, 255)));
    end
    // frame 2: checkerboard drives saturation (R9)
    for (int i = 0; i < FR; i++) push(1, (((i % W) + (i / W)) % 2) * 255);
    // frame 3: flat field, output equals input (R5)
    for (int i = 0; i < FR; i++) push(1, 128);
    // frame 4: random, flushes frame 3 through
    for (int i = 0; i < FR; i++) push(1, int'($urandom_range(0, 255)));
    push(0, 0);
    push(0, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule